// File: doc/BRIEF.md
# Burst-Locking Two-Master Bus Arbiter

This block lets two memory-mapped masters share one slave port that accepts bursts. Each master presents a command (read or write), a start address and a beat count. When no burst is active the arbiter picks one requester and passes its command straight to the slave. Once the slave accepts that command, the grant is locked to the chosen master until the whole burst is done. A write burst is done when the slave has accepted the declared number of write beats. A read burst is done when the slave has returned that many read beats.

Ties are settled round-robin. The losing master sees its wait signal held high. It never sees a read-valid pulse that belongs to another master's burst. During the data phase of a read burst no command of any kind is forwarded to the slave. The arbiter is a single module whose state is a phase, an owner, a beat counter and the most recent winner. All routing is combinational from that state.

Top module: `burst_lock_arbiter`

## Requirements
- R1: At most one master sees its waitrequest low in any cycle. A master that is not granted sees waitrequest high.
- R2: A write command accepted with burstcount N > 1 locks the slave to its master until N write beats have been accepted. Write beats from the other master reach the slave only after that.
- R3: A read command accepted with burstcount N holds the lock until N readdatavalid beats have come back. While it waits, the slave sees neither read nor write, and the other master waits.
- R4: The burst length is taken only on the edge where the command is first accepted (request high, slave waitrequest low). A burstcount presented on later beats of the same burst has no effect on the lock length.
- R5: A burstcount of 1 acts as a single transfer. For a write, the lock is free at the edge after the one accepted beat. For a read, it is free at the edge after the one returned beat. A waiting master is then accepted in the very next cycle.
- R6: With no lock held and both masters requesting, the master that did not win the last grant is chosen. After reset, master 0 wins the first tie.
- R7: Slave readdatavalid is passed only to the master that owns the read burst in progress. It is never raised to both masters at once. Readdata is carried to both masters.
- R8: During a write burst the owner may drop write, and the slave may raise waitrequest. Only cycles with write high and waitrequest low count as beats, and neither kind of pause ends the burst.
- R9: Synchronous reset (rst high) clears the lock and the beat counter. After reset both waitrequests are high while no master requests, and a new request is granted at once, even if a burst was cut short by the reset.
- R10: With no lock held, the granted master's address, burstcount, writedata and byteenable appear on the slave port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m0_address | input | ADDR_W | Master 0 start address |
| m0_burstcount | input | BCNT_W | Master 0 beat count |
| m0_read | input | 1 | Master 0 read command |
| m0_write | input | 1 | Master 0 write command / write beat |
| m0_writedata | input | DATA_W | Master 0 write data |
| m0_byteenable | input | DATA_W/8 | Master 0 byte lanes |
| m0_waitrequest | output | 1 | Master 0 stall |
| m0_readdata | output | DATA_W | Read data to master 0 |
| m0_readdatavalid | output | 1 | Read beat valid for master 0 |
| m1_address | input | ADDR_W | Master 1 start address |
| m1_burstcount | input | BCNT_W | Master 1 beat count |
| m1_read | input | 1 | Master 1 read command |
| m1_write | input | 1 | Master 1 write command / write beat |
| m1_writedata | input | DATA_W | Master 1 write data |
| m1_byteenable | input | DATA_W/8 | Master 1 byte lanes |
| m1_waitrequest | output | 1 | Master 1 stall |
| m1_readdata | output | DATA_W | Read data to master 1 |
| m1_readdatavalid | output | 1 | Read beat valid for master 1 |
| s_address | output | ADDR_W | Address to slave |
| s_burstcount | output | BCNT_W | Beat count to slave |
| s_read | output | 1 | Read command to slave |
| s_write | output | 1 | Write command / beat to slave |
| s_writedata | output | DATA_W | Write data to slave |
| s_byteenable | output | DATA_W/8 | Byte lanes to slave |
| s_waitrequest | input | 1 | Slave stall |
| s_readdata | input | DATA_W | Slave read data |
| s_readdatavalid | input | 1 | Slave read beat valid |

## Verification
Command routing, the waitrequest seen by each master and the readdatavalid steering are all combinational. A result is therefore due in the same cycle as the stimulus that causes it. The bench drives inputs just after a rising edge and samples at the falling edge of that same cycle, so a beat counts as accepted only if it is seen at that falling edge. A lock release takes effect one edge after the last beat. The bench checks this by logging the cycle number of every accepted write and every returned read beat. It then requires the next master's first beat to fall exactly one cycle after the releasing beat, or strictly later where a stall is allowed.

// File: rtl/burst_lock_arbiter.sv
module burst_lock_arbiter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BCNT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   m0_address,
  input  logic [BCNT_W-1:0]   m0_burstcount,
  input  logic                m0_read,
  input  logic                m0_write,
  input  logic [DATA_W-1:0]   m0_writedata,
  input  logic [DATA_W/8-1:0] m0_byteenable,
  output logic                m0_waitrequest,
  output logic [DATA_W-1:0]   m0_readdata,
  output logic                m0_readdatavalid,
  input  logic [ADDR_W-1:0]   m1_address,
  input  logic [BCNT_W-1:0]   m1_burstcount,
  input  logic                m1_read,
  input  logic                m1_write,
  input  logic [DATA_W-1:0]   m1_writedata,
  input  logic [DATA_W/8-1:0] m1_byteenable,
  output logic                m1_waitrequest,
  output logic [DATA_W-1:0]   m1_readdata,
  output logic                m1_readdatavalid,
  output logic [ADDR_W-1:0]   s_address,
  output logic [BCNT_W-1:0]   s_burstcount,
  output logic                s_read,
  output logic                s_write,
  output logic [DATA_W-1:0]   s_writedata,
  output logic [DATA_W/8-1:0] s_byteenable,
  input  logic                s_waitrequest,
  input  logic [DATA_W-1:0]   s_readdata,
  input  logic                s_readdatavalid
);

  localparam int BE_W = DATA_W / 8;
  localparam logic [BCNT_W-1:0] BMAX = {1'b1, {(BCNT_W-1){1'b0}}};
  localparam logic [BCNT_W-1:0] ONE  = BCNT_W'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD} phase_t;

  phase_t            phase;
  logic              owner;
  logic              last_win;
  logic [BCNT_W-1:0] cnt;

  logic              req0, req1, pick, sel, cmd_open, accept;
  logic              sel_read, sel_write;
  logic [BCNT_W-1:0] eff_bc;
  logic [BE_W-1:0]   sel_be;

  assign req0 = m0_read | m0_write;
  assign req1 = m1_read | m1_write;
  assign pick = (req0 & req1) ? ~last_win : req1;
  assign sel  = (phase == PH_IDLE) ? pick : owner;

  assign sel_read  = sel ? m1_read  : m0_read;
  assign sel_write = sel ? m1_write : m0_write;
  assign sel_be    = sel ? m1_byteenable : m0_byteenable;

  assign cmd_open = ((phase == PH_IDLE) && (req0 | req1)) || (phase == PH_WR);

  assign s_address    = sel ? m1_address    : m0_address;
  assign s_burstcount = sel ? m1_burstcount : m0_burstcount;
  assign s_writedata  = sel ? m1_writedata  : m0_writedata;
  assign s_byteenable = sel_be;
  assign s_write      = cmd_open && sel_write;
  assign s_read       = (phase == PH_IDLE) && cmd_open && sel_read && !sel_write;

  assign accept = (s_read | s_write) & ~s_waitrequest;
  assign eff_bc = (s_burstcount == '0) ? ONE : s_burstcount;

  assign m0_waitrequest = !(cmd_open && (sel == 1'b0)) || s_waitrequest;
  assign m1_waitrequest = !(cmd_open && (sel == 1'b1)) || s_waitrequest;

  assign m0_readdata = s_readdata;
  assign m1_readdata = s_readdata;
  assign m0_readdatavalid = s_readdatavalid && (phase == PH_RD) && (owner == 1'b0);
  assign m1_readdatavalid = s_readdatavalid && (phase == PH_RD) && (owner == 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      owner    <= 1'b0;
      last_win <= 1'b1;
      cnt      <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          owner    <= sel;
          last_win <= sel;
          if (s_write) begin
            cnt   <= eff_bc - ONE;
            phase <= (eff_bc == ONE) ? PH_IDLE : PH_WR;
          end else begin
            cnt   <= eff_bc;
            phase <= PH_RD;
          end
        end
        PH_WR: if (accept) begin
          cnt <= cnt - ONE;
          if (cnt == ONE) phase <= PH_IDLE;
        end
        PH_RD: if (s_readdatavalid) begin
          cnt <= cnt - ONE;
          if (cnt == ONE) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(!m0_waitrequest && !m1_waitrequest)); // R1

  AST_WR_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WR && s_write && !s_waitrequest && cnt > ONE) |=> (phase == PH_WR && $stable(owner))); // R2

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RD) |-> (!s_read && !s_write && m0_waitrequest && m1_waitrequest)); // R3

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RD && s_readdatavalid && cnt == ONE) |=> (phase == PH_IDLE)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (cnt != '0 && cnt <= BMAX)); // R4

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && s_write && !s_waitrequest && s_burstcount == ONE) |=> (phase == PH_IDLE)); // R5

  AST_RDV_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m0_readdatavalid, m1_readdatavalid})); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (phase == PH_IDLE && cnt == '0)); // R9

endmodule

// File: tb/burst_lock_arbiter_tb_top.sv
module burst_lock_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] maddr [2];
  logic [BW-1:0] mbc   [2];
  logic          mrd   [2];
  logic          mwr   [2];
  logic [DW-1:0] mwd   [2];
  logic [3:0]    mbe   [2];
  logic          mwait [2];
  logic [DW-1:0] mrdat [2];
  logic          mrdv  [2];

  logic [AW-1:0] s_addr;
  logic [BW-1:0] s_bc;
  logic          s_read, s_write;
  logic [DW-1:0] s_wd;
  logic [3:0]    s_be;
  logic          s_wait = 1'b0;
  logic [DW-1:0] s_rdata = '0;
  logic          s_rdv = 1'b0;

  burst_lock_arbiter #(.ADDR_W(AW), .DATA_W(DW), .BCNT_W(BW)) dut_i (
    .clk(clk), .rst(rst),
    .m0_address(maddr[0]), .m0_burstcount(mbc[0]), .m0_read(mrd[0]), .m0_write(mwr[0]),
    .m0_writedata(mwd[0]), .m0_byteenable(mbe[0]), .m0_waitrequest(mwait[0]),
    .m0_readdata(mrdat[0]), .m0_readdatavalid(mrdv[0]),
    .m1_address(maddr[1]), .m1_burstcount(mbc[1]), .m1_read(mrd[1]), .m1_write(mwr[1]),
    .m1_writedata(mwd[1]), .m1_byteenable(mbe[1]), .m1_waitrequest(mwait[1]),
    .m1_readdata(mrdat[1]), .m1_readdatavalid(mrdv[1]),
    .s_address(s_addr), .s_burstcount(s_bc), .s_read(s_read), .s_write(s_write),
    .s_writedata(s_wd), .s_byteenable(s_be), .s_waitrequest(s_wait),
    .s_readdata(s_rdata), .s_readdatavalid(s_rdv)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } witem_t;
  typedef struct packed { logic [AW-1:0] a; logic [7:0] n; } rd_t;

  witem_t        wq[$];
  logic [DW-1:0] rq0[$];
  logic [DW-1:0] rq1[$];
  rd_t           pend[$];
  int            wcyc[$];

  int  vectors = 0;
  int  errors  = 0;
  int  cyc     = 0;
  int  last_rdv0 = -1;
  int  last_rdv1 = -1;
  bit  stall_en = 1'b0;
  int  beat = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] wpat(int m, logic [AW-1:0] a, int k);
    return {4'(m + 1), 4'hA, 8'(k), a};
  endfunction

  function automatic logic [DW-1:0] rpat(logic [AW-1:0] a, int k);
    return {8'hD5, 8'(k), a};
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_write(int m, logic [AW-1:0] a, int n);
    for (int k = 0; k < n; k++) wq.push_back({a, wpat(m, a, k)});
  endtask

  task automatic mwrite(int m, logic [AW-1:0] a, int n, int nsend, bit gap, bit scr);
    for (int k = 0; k < nsend; k++) begin
      if (gap && k == 2) begin
        mwr[m] = 1'b0;
        tick(2);
      end
      maddr[m] = a;
      mbc[m]   = (scr && k > 0) ? BW'(1) : BW'(n);
      mwr[m]   = 1'b1;
      mwd[m]   = wpat(m, a, k);
      do @(negedge clk); while (mwait[m]);
      tick(1);
    end
    mwr[m] = 1'b0;
  endtask

  task automatic mread(int m, logic [AW-1:0] a, int n);
    for (int k = 0; k < n; k++) begin
      if (m == 0) rq0.push_back(rpat(a, k));
      else        rq1.push_back(rpat(a, k));
    end
    maddr[m] = a;
    mbc[m]   = BW'(n);
    mrd[m]   = 1'b1;
    do @(negedge clk); while (mwait[m]);
    tick(1);
    mrd[m] = 1'b0;
  endtask

  task automatic drain();
    while (wq.size() != 0 || rq0.size() != 0 || rq1.size() != 0 || pend.size() != 0) tick(1);
    tick(2);
  endtask

  // slave model: waitrequest pattern and read beat return
  initial begin
    forever begin
      @(posedge clk);
      #1;
      s_wait = stall_en && (cyc % 3 == 0);
      s_rdv  = 1'b0;
      if (rst) begin
        pend.delete();
        beat = 0;
      end else if (pend.size() != 0 && (cyc % 4) != 3) begin
        s_rdv   = 1'b1;
        s_rdata = rpat(pend[0].a, beat);
        beat++;
        if (beat == int'(pend[0].n)) begin
          void'(pend.pop_front());
          beat = 0;
        end
      end
    end
  end

  // monitor: scoreboard comparisons at mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      check(!(!mwait[0] && !mwait[1]), "R1 two masters granted", {31'd0, mwait[1]}, 32'd1);
      check(!(mrdv[0] && mrdv[1]), "R7 readdatavalid to both", {31'd0, mrdv[1]}, 32'd0);
      if (s_read && !s_wait) pend.push_back({s_addr, 8'(s_bc)});
      if (s_write && !s_wait) begin
        wcyc.push_back(cyc);
        if (wq.size() == 0) check(1'b0, "R2 unexpected write beat", s_wd, 32'd0);
        else begin
          witem_t it;
          it = wq.pop_front();
          check(s_wd == it.d && s_addr == it.a, "R2 R8 write beat order", s_wd, it.d);
        end
      end
      if (mrdv[0]) begin
        last_rdv0 = cyc;
        if (rq0.size() == 0) check(1'b0, "R7 unexpected read beat m0", mrdat[0], 32'd0);
        else begin
          logic [DW-1:0] e;
          e = rq0.pop_front();
          check(mrdat[0] == e, "R7 read beat m0", mrdat[0], e);
        end
      end
      if (mrdv[1]) begin
        last_rdv1 = cyc;
        if (rq1.size() == 0) check(1'b0, "R7 unexpected read beat m1", mrdat[1], 32'd0);
        else begin
          logic [DW-1:0] e;
          e = rq1.pop_front();
          check(mrdat[1] == e, "R7 read beat m1", mrdat[1], e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      maddr[i] = '0; mbc[i] = '0; mrd[i] = 1'b0; mwr[i] = 1'b0; mwd[i] = '0; mbe[i] = 4'hF;
    end
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    check(mwait[0] && mwait[1], "R9 reset waitrequests", {30'd0, mwait[1], mwait[0]}, 32'd3);
    check(!s_read && !s_write, "R9 reset slave idle", {30'd0, s_read, s_write}, 32'd0);
    tick(1);

    // R10: same-cycle forwarding
    expect_write(1, 16'h0040, 1);
    maddr[1] = 16'h0040; mbc[1] = 4'd1; mwd[1] = wpat(1, 16'h0040, 0); mbe[1] = 4'b0101; mwr[1] = 1'b1;
    @(negedge clk);
    check(s_addr == 16'h0040, "R10 address forwarded", 32'(s_addr), 32'h40);
    check(s_bc == 4'd1 && s_be == 4'b0101, "R10 burstcount/byteenable forwarded", {24'd0, s_bc, s_be}, 32'h15);
    check(!mwait[1] && mwait[0], "R1 only requester granted", {30'd0, mwait[1], mwait[0]}, 32'd1);
    tick(1);
    mwr[1] = 1'b0; mbe[1] = 4'hF;
    drain();

    // R6: tie after m1 won -> m0 first
    wcyc.delete();
    expect_write(0, 16'h0100, 1);
    expect_write(1, 16'h0200, 1);
    fork
      mwrite(0, 16'h0100, 1, 1, 1'b0, 1'b0);
      mwrite(1, 16'h0200, 1, 1, 1'b0, 1'b0);
    join
    drain();
    check(wcyc.size() == 2 && wcyc[1] == wcyc[0] + 1, "R5 single write frees lock next cycle",
          32'(wcyc.size() == 2 ? wcyc[1] - wcyc[0] : -1), 32'd1);

    // R6: m0 wins alone, next tie goes to m1
    expect_write(0, 16'h0110, 1);
    mwrite(0, 16'h0110, 1, 1, 1'b0, 1'b0);
    drain();
    expect_write(1, 16'h0210, 1);
    expect_write(0, 16'h0120, 1);
    fork
      mwrite(0, 16'h0120, 1, 1, 1'b0, 1'b0);
      mwrite(1, 16'h0210, 1, 1, 1'b0, 1'b0);
    join
    drain();

    // R2 + R8: m0 write burst with a gap, m1 waits
    expect_write(0, 16'h0300, 4);
    expect_write(1, 16'h0400, 2);
    fork
      mwrite(0, 16'h0300, 4, 4, 1'b1, 1'b0);
      begin tick(1); mwrite(1, 16'h0400, 2, 2, 1'b0, 1'b0); end
    join
    drain();

    // R4 + R8: burstcount changed mid-burst ignored, slave stalls
    stall_en = 1'b1;
    expect_write(1, 16'h0500, 3);
    expect_write(0, 16'h0600, 1);
    fork
      mwrite(1, 16'h0500, 3, 3, 1'b0, 1'b1);
      begin tick(2); mwrite(0, 16'h0600, 1, 1, 1'b0, 1'b0); end
    join
    drain();
    stall_en = 1'b0;

    // R3: read lock holds off m1's write until all beats return
    wcyc.delete();
    expect_write(1, 16'h0800, 1);
    fork
      mread(0, 16'h0700, 4);
      begin tick(1); mwrite(1, 16'h0800, 1, 1, 1'b0, 1'b0); end
      begin
        tick(2);
        @(negedge clk);
        check(!s_write && !s_read && mwait[1], "R3 no command during read data phase",
              {29'd0, s_write, s_read, mwait[1]}, 32'd1);
      end
    join
    drain();
    check(wcyc.size() == 1 && wcyc[0] > last_rdv0, "R3 write after last read beat",
          32'(wcyc.size() == 1 ? wcyc[0] : -1), 32'(last_rdv0 + 1));

    // R7: both masters read with stalls
    stall_en = 1'b1;
    fork
      mread(0, 16'h0900, 2);
      mread(1, 16'h0A00, 3);
    join
    drain();
    stall_en = 1'b0;

    // R5: single-beat read releases after its one beat
    wcyc.delete();
    expect_write(0, 16'h0C00, 1);
    fork
      mread(1, 16'h0B00, 1);
      begin tick(1); mwrite(0, 16'h0C00, 1, 1, 1'b0, 1'b0); end
    join
    drain();
    check(wcyc.size() == 1 && wcyc[0] == last_rdv1 + 1, "R5 single read frees lock next cycle",
          32'(wcyc.size() == 1 ? wcyc[0] : -1), 32'(last_rdv1 + 1));

    // R9: reset in the middle of a write burst clears the lock
    expect_write(0, 16'h0D00, 2);
    mwrite(0, 16'h0D00, 4, 2, 1'b0, 1'b0);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    @(negedge clk);
    check(mwait[0] && mwait[1], "R9 no grant after reset", {30'd0, mwait[1], mwait[0]}, 32'd3);
    tick(1);
    expect_write(1, 16'h0E00, 1);
    maddr[1] = 16'h0E00; mbc[1] = 4'd1; mwd[1] = wpat(1, 16'h0E00, 0); mwr[1] = 1'b1;
    @(negedge clk);
    check(!mwait[1], "R9 counter cleared, new grant at once", {31'd0, mwait[1]}, 32'd0);
    tick(1);
    mwr[1] = 1'b0;
    drain();

    check(wq.size() == 0 && rq0.size() == 0 && rq1.size() == 0, "R2 scoreboard empty at end",
          32'(wq.size() + rq0.size() + rq1.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule